// File: doc/BRIEF.md
# Floating-Point Reciprocal Seed Unit

This unit is the first step of a software division sequence. Each clock it accepts a dividend and a divisor in an extended register format: a sign, a 17-bit biased exponent (bias 0xFFFF) and a 64-bit significand whose leading one is explicit. For an ordinary pair of operands it returns a low-precision approximation of the divisor's reciprocal and raises a predicate. Software reads the predicate as "go on with the Newton-style refinement". The seed comes from a 256-entry table that is computed at elaboration time. The index is the eight significand bits just below the explicit leading one.

When the result is already fixed by the floating-point rules, the unit writes that final value and clears the predicate. This covers NaN operands, 0/0, inf/inf, division by zero, an infinite or zero operand, and a reciprocal that would fall below the exponent range. Software can then skip refinement without a branch on the operand classes. Each operand carries a deferred-exception tag bit. A tagged source produces a tagged result with the predicate cleared. A qualifying-predicate input of 0 nullifies the operation: nothing is written and the predicate reads 0.

The result is registered, so it appears one clock after the operands are presented. The divisor is assumed to be normalized (significand bit 63 set) whenever it is finite and nonzero.

Top module: `rcp_seed_unit`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: When `qp` is 0, the next cycle shows `res_we`=0 and `res_pred`=0, and `res_nat`, `res_sign`, `res_exp` and `res_sig` keep their previous values.
- R3: On the seed path, `res_sig` is {1'b1, T[k], 53'b0}. Here k is divisor significand bits [62:55], and T[k] = round((2/(1+(k+0.5)/256) - 1) * 1024) is a 10-bit value.
- R4: For every index k, the seed has a relative error below 2^-8.8 against 1/x for every divisor significand x in [1+k/256, 1+(k+1)/256].
- R5: On the seed path, `res_pred`=1, `res_sign` equals the divisor sign and `res_exp` = 0x1FFFD - divisor exponent. The seed path is taken when both operands are finite and nonzero, no tag is set and the divisor exponent is below 0x1FFFD.
- R6: If either tag bit is set and `qp` is 1, the result has `res_nat`=1, sign, exponent and significand all 0, `res_pred`=0 and `res_we`=1. This check comes before all the operand cases.
- R7: NaN means exponent 0x1FFFF with significand bits [62:0] not all zero. A NaN dividend is returned with significand bit 62 forced to 1. If only the divisor is a NaN, the divisor is returned in the same way. `res_pred` is 0.
- R8: 0/0 and inf/inf return the default NaN: sign 1, exponent 0x1FFFF, significand 0xC000_0000_0000_0000, with `res_pred`=0. Zero means exponent 0 and significand 0. Infinity means exponent 0x1FFFF and significand bits [62:0] equal to 0.
- R9: A non-NaN dividend over a zero divisor, and an infinite dividend over a finite divisor, return infinity. The result sign is the XOR of the operand signs, the exponent is 0x1FFFF, the significand is 0x8000_0000_0000_0000 and `res_pred` is 0.
- R10: A zero dividend over a finite nonzero divisor, and a finite dividend over an infinite divisor, return zero with the XOR sign and `res_pred`=0.
- R11: A finite nonzero dividend over a finite divisor with exponent 0x1FFFD or 0x1FFFE returns zero with the XOR sign and `res_pred`=0.
- R12: With `qp` at 1, every result appears exactly one clock after its operands, with `res_we`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qp | input | 1 | Qualifying predicate; 0 nullifies the operation |
| a_sign | input | 1 | Dividend sign |
| a_exp | input | 17 | Dividend biased exponent |
| a_sig | input | 64 | Dividend significand |
| a_tag | input | 1 | Dividend deferred-exception tag |
| b_sign | input | 1 | Divisor sign |
| b_exp | input | 17 | Divisor biased exponent |
| b_sig | input | 64 | Divisor significand |
| b_tag | input | 1 | Divisor deferred-exception tag |
| res_nat | output | 1 | Result carries the deferred-exception tag |
| res_sign | output | 1 | Result sign |
| res_exp | output | 17 | Result biased exponent |
| res_sig | output | 64 | Result significand |
| res_we | output | 1 | Destination write enable |
| res_pred | output | 1 | 1 = seed written, refinement required |

## Verification
The assertions check on every cycle the properties that hold whatever the operands are. A nullified slot writes nothing and holds the result. A tagged source gives a tagged result with the predicate low. Every special case clears the predicate. A raised predicate always comes with a well-formed seed whose sign matches the divisor and whose exponent plus the divisor's exponent equals 0x1FFFD. What only the bench scenarios can show is the value of each table entry and its accuracy across all 256 indices, checked at both ends of each interval with real arithmetic. The bench scenarios also establish the exact special results for each pairing of operand classes and the priority among them.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  localparam int EXP_W = 17;
  localparam int SIG_W = 64;

  localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0] EXP_BIAS = {1'b0, {(EXP_W-1){1'b1}}};
  // Smallest divisor exponent whose reciprocal no longer has a positive biased exponent.
  localparam logic [EXP_W-1:0] EXP_LIMIT = EXP_W'((2 * int'(EXP_BIAS)) - 1);

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
  } fpx_t;

  typedef struct packed {
    logic is_zero;
    logic is_inf;
    logic is_nan;
  } opcls_t;

  // Rounded fraction of 2/(1 + (i+0.5)/2^idx_w), scaled by 2^ent_w, computed in integers.
  function automatic int unsigned seed_entry(input int i, input int idx_w, input int ent_w);
    longint unsigned num;
    longint unsigned den;
    longint unsigned q;
    num = longint'(1) << (idx_w + ent_w + 3);
    den = (longint'(1) << (idx_w + 1)) + longint'(2 * i + 1);
    q   = (num + den) / (2 * den);
    return int'(q - (longint'(1) << ent_w));
  endfunction

  // Biased exponent of the reciprocal when the seed significand lies in [1,2).
  function automatic logic [EXP_W-1:0] recip_exp(input logic [EXP_W-1:0] e);
    return EXP_LIMIT - e;
  endfunction

  function automatic fpx_t make_inf(input logic s);
    fpx_t r;
    r.sign = s;
    r.exp  = EXP_ONES;
    r.sig  = {1'b1, {(SIG_W-1){1'b0}}};
    return r;
  endfunction

  function automatic fpx_t make_zero(input logic s);
    fpx_t r;
    r.sign = s;
    r.exp  = '0;
    r.sig  = '0;
    return r;
  endfunction

  function automatic fpx_t make_qnan(input fpx_t x);
    fpx_t r;
    r = x;
    r.sig[SIG_W-2] = 1'b1;
    return r;
  endfunction

  function automatic fpx_t default_nan();
    fpx_t r;
    r.sign = 1'b1;
    r.exp  = EXP_ONES;
    r.sig  = {2'b11, {(SIG_W-2){1'b0}}};
    return r;
  endfunction

endpackage

// File: rtl/rcp_opclass.sv
module rcp_opclass
  import rcp_pkg::*;
(
  input  fpx_t   op,
  output opcls_t cls
);

  logic exp_max;
  logic frac_zero;

  assign exp_max     = (op.exp == EXP_ONES);
  assign frac_zero   = (op.sig[SIG_W-2:0] == '0);
  assign cls.is_zero = (op.exp == '0) && (op.sig == '0);
  assign cls.is_inf  = exp_max && frac_zero;
  assign cls.is_nan  = exp_max && !frac_zero;

endmodule

// File: rtl/rcp_seed_rom.sv
module rcp_seed_rom #(
  parameter int IDX_W = 8,
  parameter int ENT_W = 10
) (
  input  logic [IDX_W-1:0] idx,
  output logic [ENT_W-1:0] entry
);

  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign table_q[g] = ENT_W'(rcp_pkg::seed_entry(g, IDX_W, ENT_W));
  end

  assign entry = table_q[idx];

endmodule

// File: rtl/rcp_resolve.sv
module rcp_resolve
  import rcp_pkg::*;
#(
  parameter int ENT_W = 10
) (
  input  fpx_t             a,
  input  fpx_t             b,
  input  opcls_t           ca,
  input  opcls_t           cb,
  input  logic             a_tag,
  input  logic             b_tag,
  input  logic [ENT_W-1:0] entry,
  output fpx_t             res,
  output logic             nat,
  output logic             pred,
  output logic             ev_tag,
  output logic             ev_nan,
  output logic             ev_invalid,
  output logic             ev_inf,
  output logic             ev_zero,
  output logic             ev_seed
);

  localparam int PAD_W = SIG_W - 1 - ENT_W;

  logic qsign;
  logic tiny;

  assign qsign = a.sign ^ b.sign;
  assign tiny  = (b.exp >= EXP_LIMIT);

  always_comb begin
    res        = make_zero(1'b0);
    nat        = 1'b0;
    pred       = 1'b0;
    ev_tag     = 1'b0;
    ev_nan     = 1'b0;
    ev_invalid = 1'b0;
    ev_inf     = 1'b0;
    ev_zero    = 1'b0;
    ev_seed    = 1'b0;
    if (a_tag || b_tag) begin
      nat    = 1'b1;
      ev_tag = 1'b1;
    end else if (ca.is_nan) begin
      res    = make_qnan(a);
      ev_nan = 1'b1;
    end else if (cb.is_nan) begin
      res    = make_qnan(b);
      ev_nan = 1'b1;
    end else if ((ca.is_zero && cb.is_zero) || (ca.is_inf && cb.is_inf)) begin
      res        = default_nan();
      ev_invalid = 1'b1;
    end else if (cb.is_zero || ca.is_inf) begin
      res    = make_inf(qsign);
      ev_inf = 1'b1;
    end else if (ca.is_zero || cb.is_inf || tiny) begin
      res     = make_zero(qsign);
      ev_zero = 1'b1;
    end else begin
      res.sign = b.sign;
      res.exp  = recip_exp(b.exp);
      res.sig  = {1'b1, entry, {PAD_W{1'b0}}};
      pred     = 1'b1;
      ev_seed  = 1'b1;
    end
  end

endmodule

// File: rtl/rcp_seed_unit.sv
module rcp_seed_unit #(
  parameter int IDX_W = 8,
  parameter int ENT_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        qp,
  input  logic        a_sign,
  input  logic [16:0] a_exp,
  input  logic [63:0] a_sig,
  input  logic        a_tag,
  input  logic        b_sign,
  input  logic [16:0] b_exp,
  input  logic [63:0] b_sig,
  input  logic        b_tag,
  output logic        res_nat,
  output logic        res_sign,
  output logic [16:0] res_exp,
  output logic [63:0] res_sig,
  output logic        res_we,
  output logic        res_pred
);
  import rcp_pkg::*;

  localparam int IDX_HI = SIG_W - 2;
  localparam int IDX_LO = SIG_W - 1 - IDX_W;

  fpx_t             op_a;
  fpx_t             op_b;
  opcls_t           cls_a;
  opcls_t           cls_b;
  logic [IDX_W-1:0] seed_idx;
  logic [ENT_W-1:0] seed_val;
  fpx_t             nxt_res;
  logic             nxt_nat;
  logic             nxt_pred;

  // Named events for the checker
  logic ev_tag, ev_nan, ev_invalid, ev_inf, ev_zero, ev_seed;

  assign op_a     = '{sign: a_sign, exp: a_exp, sig: a_sig};
  assign op_b     = '{sign: b_sign, exp: b_exp, sig: b_sig};
  assign seed_idx = b_sig[IDX_HI:IDX_LO];

  rcp_opclass u_cls_a (.op(op_a), .cls(cls_a));
  rcp_opclass u_cls_b (.op(op_b), .cls(cls_b));

  rcp_seed_rom #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_rom (
    .idx  (seed_idx),
    .entry(seed_val)
  );

  rcp_resolve #(.ENT_W(ENT_W)) u_resolve (
    .a         (op_a),
    .b         (op_b),
    .ca        (cls_a),
    .cb        (cls_b),
    .a_tag     (a_tag),
    .b_tag     (b_tag),
    .entry     (seed_val),
    .res       (nxt_res),
    .nat       (nxt_nat),
    .pred      (nxt_pred),
    .ev_tag    (ev_tag),
    .ev_nan    (ev_nan),
    .ev_invalid(ev_invalid),
    .ev_inf    (ev_inf),
    .ev_zero   (ev_zero),
    .ev_seed   (ev_seed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_nat  <= 1'b0;
      res_sign <= 1'b0;
      res_exp  <= '0;
      res_sig  <= '0;
      res_we   <= 1'b0;
      res_pred <= 1'b0;
    end else begin
      res_we   <= qp;
      res_pred <= qp & nxt_pred;
      if (qp) begin
        res_nat  <= nxt_nat;
        res_sign <= nxt_res.sign;
        res_exp  <= nxt_res.exp;
        res_sig  <= nxt_res.sig;
      end
    end
  end

endmodule

// File: rtl/rcp_seed_unit_chk.sv
module rcp_seed_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        qp,
  input logic        a_tag,
  input logic        b_tag,
  input logic        b_sign,
  input logic [16:0] b_exp,
  input logic        ev_seed,
  input logic        ev_nan,
  input logic        ev_invalid,
  input logic        ev_inf,
  input logic        ev_zero,
  input logic        res_nat,
  input logic        res_sign,
  input logic [16:0] res_exp,
  input logic [63:0] res_sig,
  input logic        res_we,
  input logic        res_pred
);

  AST_NULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !qp |=> (!res_we && !res_pred)); // R2

  AST_NULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !qp |=> ($stable(res_sig) && $stable(res_exp) && $stable(res_sign) && $stable(res_nat))); // R2

  AST_TAG_PROPAGATES: assert property (@(posedge clk) disable iff (!rst_n)
    (qp && (a_tag || b_tag)) |=> (res_nat && !res_pred && res_we)); // R6

  AST_SEED_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    res_pred |-> (res_sig[63] && (res_sig[52:0] == 53'd0) && !res_nat)); // R3

  AST_SEED_SIGN_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (qp && ev_seed) |=> (res_pred && (res_sign == $past(b_sign))
                         && ((res_exp + $past(b_exp)) == 17'h1FFFD))); // R5

  AST_SPECIAL_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (qp && (ev_nan || ev_invalid || ev_inf || ev_zero)) |=> (!res_pred && res_we && !res_nat)); // R7

  AST_ONE_CYCLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    qp |=> res_we); // R12

  AST_PRED_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    res_pred |-> res_we); // R12

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!res_we && !res_pred && !res_nat); // R1
    end
  end

endmodule

bind rcp_seed_unit rcp_seed_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .qp        (qp),
  .a_tag     (a_tag),
  .b_tag     (b_tag),
  .b_sign    (b_sign),
  .b_exp     (b_exp),
  .ev_seed   (ev_seed),
  .ev_nan    (ev_nan),
  .ev_invalid(ev_invalid),
  .ev_inf    (ev_inf),
  .ev_zero   (ev_zero),
  .res_nat   (res_nat),
  .res_sign  (res_sign),
  .res_exp   (res_exp),
  .res_sig   (res_sig),
  .res_we    (res_we),
  .res_pred  (res_pred)
);

// File: tb/rcp_seed_unit_tb.sv
module rcp_seed_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qp = 1'b0;
  logic        a_sign = 1'b0, b_sign = 1'b0, a_tag = 1'b0, b_tag = 1'b0;
  logic [16:0] a_exp = '0, b_exp = '0;
  logic [63:0] a_sig = '0, b_sig = '0;
  logic        res_nat, res_sign, res_we, res_pred;
  logic [16:0] res_exp;
  logic [63:0] res_sig;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  // {nat, sign, exp, sig} of the last written result
  logic [82:0] last_val = '0;

  always #5 clk = ~clk;

  rcp_seed_unit u_dut (
    .clk(clk), .rst_n(rst_n), .qp(qp),
    .a_sign(a_sign), .a_exp(a_exp), .a_sig(a_sig), .a_tag(a_tag),
    .b_sign(b_sign), .b_exp(b_exp), .b_sig(b_sig), .b_tag(b_tag),
    .res_nat(res_nat), .res_sign(res_sign), .res_exp(res_exp), .res_sig(res_sig),
    .res_we(res_we), .res_pred(res_pred)
  );

  function automatic int ref_entry(input int k);
    real r;
    r = 2.0 / (1.0 + (real'(k) + 0.5) / 256.0);
    return int'($floor((r - 1.0) * 1024.0 + 0.5));
  endfunction

  function automatic bit is_nan_v(input logic [16:0] e, input logic [63:0] s);
    return (e == 17'h1FFFF) && (s[62:0] != 63'd0);
  endfunction
  function automatic bit is_inf_v(input logic [16:0] e, input logic [63:0] s);
    return (e == 17'h1FFFF) && (s[62:0] == 63'd0);
  endfunction
  function automatic bit is_zero_v(input logic [16:0] e, input logic [63:0] s);
    return (e == 17'd0) && (s == 64'd0);
  endfunction

  // Expected {nat, sign, exp, sig, pred} from the requirements
  function automatic logic [83:0] model(
      input logic as, input logic [16:0] ae, input logic [63:0] am, input logic at,
      input logic bs, input logic [16:0] be, input logic [63:0] bm, input logic bt);
    logic x;
    x = as ^ bs;
    if (at || bt)                               return {1'b1, 1'b0, 17'd0, 64'd0, 1'b0};
    if (is_nan_v(ae, am))                       return {1'b0, as, ae, am | 64'h4000_0000_0000_0000, 1'b0};
    if (is_nan_v(be, bm))                       return {1'b0, bs, be, bm | 64'h4000_0000_0000_0000, 1'b0};
    if ((is_zero_v(ae, am) && is_zero_v(be, bm)) || (is_inf_v(ae, am) && is_inf_v(be, bm)))
                                                return {1'b0, 1'b1, 17'h1FFFF, 64'hC000_0000_0000_0000, 1'b0};
    if (is_zero_v(be, bm) || is_inf_v(ae, am))  return {1'b0, x, 17'h1FFFF, 64'h8000_0000_0000_0000, 1'b0};
    if (is_zero_v(ae, am) || is_inf_v(be, bm) || be >= 17'h1FFFD)
                                                return {1'b0, x, 17'd0, 64'd0, 1'b0};
    return {1'b0, bs, 17'h1FFFD - be,
            {1'b1, 10'(ref_entry(int'(bm[62:55]))), 53'd0}, 1'b1};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // Drive one operation at the falling edge and check one clock later.
  task automatic do_op(input string req, input logic q,
      input logic as, input logic [16:0] ae, input logic [63:0] am, input logic at,
      input logic bs, input logic [16:0] be, input logic [63:0] bm, input logic bt);
    logic [83:0] e;
    @(negedge clk);
    qp = q; a_sign = as; a_exp = ae; a_sig = am; a_tag = at;
    b_sign = bs; b_exp = be; b_sig = bm; b_tag = bt;
    e = model(as, ae, am, at, bs, be, bm, bt);
    @(posedge clk);
    #1;
    if (q) begin
      check(req, 128'({res_nat, res_sign, res_exp, res_sig, res_pred, res_we}), 128'({e, 1'b1}));
      last_val = e[83:1];
    end else begin
      check(req, 128'({res_nat, res_sign, res_exp, res_sig, res_pred, res_we}),
            128'({last_val, 1'b0, 1'b0}));
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic rnd_operand(output logic s, output logic [16:0] e, output logic [63:0] m);
    int kind;
    kind = int'($urandom_range(0, 9));
    s = 1'($urandom());
    case (kind)
      0: begin e = 17'd0; m = 64'd0; end
      1: begin e = 17'h1FFFF; m = 64'h8000_0000_0000_0000; end
      2: begin e = 17'h1FFFF; m = rnd64() | 64'h0000_0000_0000_0001; end
      3: begin e = 17'h1FFFD + 17'($urandom_range(0, 1)); m = rnd64() | 64'h8000_0000_0000_0000; end
      default: begin e = 17'($urandom_range(1, 17'h1FFFC)); m = rnd64() | 64'h8000_0000_0000_0000; end
    endcase
  endtask

  localparam logic [63:0] ONE  = 64'h8000_0000_0000_0000;
  localparam logic [16:0] BIAS = 17'h0FFFF;

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 128'({res_nat, res_sign, res_exp, res_sig, res_we, res_pred}), 128'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 R5: divisor significand exactly 1.0
    do_op("R5 sig one", 1'b1, 1'b0, BIAS, ONE, 1'b0, 1'b0, BIAS, ONE, 1'b0);
    do_op("R5 neg div", 1'b1, 1'b0, BIAS, ONE, 1'b0, 1'b1, 17'd1, ONE | 64'h7FFF_0000_0000_1234, 1'b0);
    do_op("R5 top exp", 1'b1, 1'b1, BIAS, ONE, 1'b0, 1'b0, 17'h1FFFC, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);

    // R3 R4: sweep every index, low and high ends of each interval
    for (int k = 0; k < 256; k++) begin
      logic [63:0] m;
      real x_lo, x_hi, sv, err_lo, err_hi;
      m = {1'b1, 8'(k), 55'd0};
      do_op("R3 table", 1'b1, 1'b0, BIAS, ONE, 1'b0, 1'b0, BIAS, m, 1'b0);
      sv = (1.0 + real'(res_sig[62:53]) / 1024.0) / 2.0;   // exponent 0xFFFE, i.e. 2^-1
      x_lo = 1.0 + real'(k) / 256.0;
      x_hi = 1.0 + real'(k + 1) / 256.0;
      err_lo = 1.0 - x_lo * sv;
      err_hi = 1.0 - x_hi * sv;
      if (err_lo < 0.0) err_lo = -err_lo;
      if (err_hi < 0.0) err_hi = -err_hi;
      n_tests++;
      if (err_lo > 0.00224 || err_hi > 0.00224 || res_exp != 17'h0FFFE) begin
        n_fail++;
        $display("FAIL R4 index %0d actual err %f/%f exp %h expected err<0.00224 exp 0fffe",
                 k, err_lo, err_hi, res_exp);
      end
      do_op("R3 low bits", 1'b1, 1'b0, BIAS, ONE, 1'b0, 1'b0, BIAS, m | (rnd64() >> 9), 1'b0);
    end

    // R2: nullified slots hold the previous result
    do_op("R2 null",   1'b0, 1'b0, BIAS, ONE, 1'b0, 1'b1, 17'h12345, ONE, 1'b0);
    do_op("R2 null nat", 1'b0, 1'b0, BIAS, ONE, 1'b1, 1'b0, BIAS, ONE, 1'b1);

    // R6: tags win over every case
    do_op("R6 a tag",  1'b1, 1'b0, 17'h1FFFF, 64'hC000_0000_0000_0001, 1'b1, 1'b0, BIAS, ONE, 1'b0);
    do_op("R6 b tag",  1'b1, 1'b0, BIAS, ONE, 1'b0, 1'b0, 17'd0, 64'd0, 1'b1);
    do_op("R2 after tag", 1'b0, 1'b0, BIAS, ONE, 1'b0, 1'b0, BIAS, ONE, 1'b0);

    // R7: NaN priority and quieting
    do_op("R7 a nan",  1'b1, 1'b1, 17'h1FFFF, 64'h8000_0000_0000_0005, 1'b0, 1'b0, 17'h1FFFF, 64'h8000_0000_0000_0009, 1'b0);
    do_op("R7 b nan",  1'b1, 1'b0, BIAS, ONE, 1'b0, 1'b1, 17'h1FFFF, 64'hC000_0000_0000_0077, 1'b0);

    // R8: invalid operations
    do_op("R8 0/0",    1'b1, 1'b0, 17'd0, 64'd0, 1'b0, 1'b1, 17'd0, 64'd0, 1'b0);
    do_op("R8 inf/inf", 1'b1, 1'b1, 17'h1FFFF, ONE, 1'b0, 1'b1, 17'h1FFFF, ONE, 1'b0);

    // R9: infinities
    do_op("R9 x/0",    1'b1, 1'b1, BIAS, ONE, 1'b0, 1'b0, 17'd0, 64'd0, 1'b0);
    do_op("R9 inf/0",  1'b1, 1'b0, 17'h1FFFF, ONE, 1'b0, 1'b1, 17'd0, 64'd0, 1'b0);
    do_op("R9 inf/x",  1'b1, 1'b0, 17'h1FFFF, ONE, 1'b0, 1'b1, BIAS, ONE, 1'b0);

    // R10: zeros
    do_op("R10 0/x",   1'b1, 1'b1, 17'd0, 64'd0, 1'b0, 1'b1, BIAS, ONE, 1'b0);
    do_op("R10 x/inf", 1'b1, 1'b0, BIAS, ONE, 1'b0, 1'b1, 17'h1FFFF, ONE, 1'b0);

    // R11: reciprocal below range
    do_op("R11 exp 1fffd", 1'b1, 1'b1, BIAS, ONE, 1'b0, 1'b0, 17'h1FFFD, ONE, 1'b0);
    do_op("R11 exp 1fffe", 1'b1, 1'b0, BIAS, ONE, 1'b0, 1'b0, 17'h1FFFE, ONE, 1'b0);

    // R12: back-to-back random stream, mixed classes, tags and nullified slots
    for (int t = 0; t < 3000; t++) begin
      logic as, bs, q, at, bt;
      logic [16:0] ae, be;
      logic [63:0] am, bm;
      rnd_operand(as, ae, am);
      rnd_operand(bs, be, bm);
      q  = ($urandom_range(0, 7) != 0);
      at = ($urandom_range(0, 31) == 0);
      bt = ($urandom_range(0, 31) == 0);
      do_op("R12 random", q, as, ae, am, at, bs, be, bm, bt);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule